// File: doc/BRIEF.md
# Manufacturing Test Mode Controller

This block picks the manufacturing test mode of a chip and runs a NAND-chain continuity test across a configurable row of pad cells. When the active-low test enable is asserted, a three-bit select code is decoded. On each rising edge of the power-good input, the decoded result is stored as the active mode. The stored mode does not change until the next rising edge of power-good. Reset puts the block in normal mode. While no test mode is active, the core's own output enables, result-pad data and auxiliary enable pass straight through.

There are two test modes. In the high-impedance mode, every pad enable is forced low, and that includes the result pad and the auxiliary pad. In NAND-chain mode, every pad in the row is released so that it acts as an input. The result pad and the auxiliary pad keep driving. The pad inputs feed an ordered string of two-input NAND stages, and the last stage drives the result pad.

Pads whose input stage inverts are marked by a parameter mask. Their inputs are inverted before they enter the chain, so these pads idle low and all other pads idle high. A tester drives every pad to its idle level. It then flips the pads one at a time, in chain order, and watches the result pad change with each flip.

Top module: `test_mode_ctrl`

## Requirements
- R1: After reset, and before the first rising edge of power-good, the mode is normal. In normal mode, `pad_oe` equals `core_oe`, `result_oe` equals `core_res_oe` and `aux_oe` equals `core_aux_oe`.
- R2: If `test_n` is high when the power-good rising edge is sampled, normal mode is stored, whatever the value of `sel`.
- R3: The mode is stored only at the clock edge that first samples `pwr_good` high after it was low. The outputs show the new mode right after that edge. Changes on `sel` or `test_n` at any other time have no effect.
- R4: With `test_n` low, `sel[2]` equal to 0 selects NAND-chain mode, whatever the values of `sel[1:0]`.
- R5: With `test_n` low, `sel` = 3'b110 also selects NAND-chain mode.
- R6: With `test_n` low, `sel` = 3'b101 selects high-impedance mode. In this mode `pad_oe`, `result_oe` and `aux_oe` are all 0.
- R7: With `test_n` low, `sel` = 3'b100 or 3'b111 selects normal mode.
- R8: In NAND-chain mode, `pad_oe` is all zeros and both `result_oe` and `aux_oe` are 1.
- R9: In NAND-chain mode, `result_o` comes from the last NAND stage. With every pad at its idle level, `result_o` is 1 when N_PADS is even and 0 when N_PADS is odd. A pad is inverting when its bit in INV_MASK is 1, and its idle level is 0. Every other pad idles at 1.
- R10: Starting from idle, pads are flipped one at a time from index 0 upward. Each pad stays at its new level once flipped. Every flip inverts `result_o`.
- R11: Flipping an inverting pad from 0 to 1 counts as a chain toggle, in the same way as flipping a non-inverting pad from 1 to 0.
- R12: Outside NAND-chain mode, `result_o` equals `core_res_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_n | input | 1 | Active-low test enable |
| sel | input | 3 | Test mode select code |
| pwr_good | input | 1 | Power-good; a rising edge stores the mode |
| chain_in | input | N_PADS | Pad input levels, index 0 first in the chain |
| core_oe | input | N_PADS | Core output enables for the pads |
| core_res_o | input | 1 | Core data for the result pad |
| core_res_oe | input | 1 | Core enable for the result pad |
| core_aux_oe | input | 1 | Core enable for the auxiliary pad |
| pad_oe | output | N_PADS | Final pad output enables |
| result_o | output | 1 | Result pad data |
| result_oe | output | 1 | Result pad enable |
| aux_oe | output | 1 | Auxiliary pad enable |

## Verification
A wrong stored mode appears in all three enable outputs just after the clock edge that samples the power-good rise. The bench checks each select code at that point, and also checks again after the select lines change while power-good stays high.

A wrong chain link, or a wrong inversion mask bit, shows up on `result_o` during the same cycle as the pad flip. The stepwise walk covers every index, so a fault at any position is reported when the tester reaches that pad.

// File: rtl/tmc_pkg.sv
// Package: shared types for the test mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package tmc_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL   = 2'd0,
        TM_CHAIN    = 2'd1,
        TM_TRISTATE = 2'd2
    } tm_mode_e;

endpackage

// File: rtl/tmc_mode_decode.sv
// Module: tmc_mode_decode
// Turns the select code and test enable into a mode value, using no state.
// Assumes: the caller samples the result only at the power-good capture edge.
module tmc_mode_decode
    import tmc_pkg::*;
(
    input  logic       test_n,
    input  logic [2:0] sel,
    output tm_mode_e   mode_dec
);

    // Priority decode: the enable first, then the chain codes, then high-impedance.
    always_comb begin
        if (test_n) begin
            mode_dec = TM_NORMAL;
        end else if (!sel[2]) begin
            mode_dec = TM_CHAIN;
        end else if (sel[1:0] == 2'b10) begin
            mode_dec = TM_CHAIN;
        end else if (sel[1:0] == 2'b01) begin
            mode_dec = TM_TRISTATE;
        end else begin
            mode_dec = TM_NORMAL;
        end
    end

endmodule

// File: rtl/tmc_mode_latch.sv
// Module: tmc_mode_latch
// Stores the decoded mode when power-good rises, then holds it.
// Assumes: pwr_good is synchronous to clk. An edge is a sample of 1 after a sample of 0.
module tmc_mode_latch
    import tmc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_good,
    input  tm_mode_e mode_dec,
    output tm_mode_e mode_q
);

    logic pg_q;
    logic pg_rise;

    // Rising-edge detect against the value from the previous cycle.
    assign pg_rise = pwr_good && !pg_q;

    // Edge history and mode register; reset gives normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q   <= 1'b0;
            mode_q <= TM_NORMAL;
        end else begin
            pg_q <= pwr_good;
            if (pg_rise) begin
                mode_q <= mode_dec;
            end
        end
    end

    // R3: with no power-good rise, the stored mode stays as it was.
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_rise |=> $stable(mode_q));

    // R3: at a power-good rise, the stored mode follows the decoder.
    assert_mode_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_rise |=> (mode_q == $past(mode_dec)));

endmodule

// File: rtl/tmc_nand_chain.sv
// Module: tmc_nand_chain
// String of two-input NAND stages over the pad inputs. Pads marked in INV_MASK are inverted first.
// Assumes: stage 0 is a constant 1. The chain has no registers.
module tmc_nand_chain #(
    parameter int                  N_PADS   = 16,
    parameter logic [N_PADS-1:0]   INV_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PADS-1:0] chain_in,
    output logic              chain_out
);

    localparam logic IDLE_RESULT = ((N_PADS % 2) == 0);

    logic [N_PADS-1:0] norm;
    logic [N_PADS:0]   stage;

    assign stage[0] = 1'b1;

    generate
        for (genvar k = 0; k < N_PADS; k++) begin : g_stage
            // Normalise pad k, so that idle is always 1 at the NAND input.
            if (INV_MASK[k]) begin : g_inv
                assign norm[k] = ~chain_in[k];
            end else begin : g_pass
                assign norm[k] = chain_in[k];
            end
            // Stage k+1 combines the previous stage with pad k.
            assign stage[k+1] = ~(stage[k] & norm[k]);
        end
    endgenerate

    assign chain_out = stage[N_PADS];

    // R9: with every pad idle, the output depends only on the chain length.
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&norm) |-> (chain_out == IDLE_RESULT));

    // R10: when pad 0 is active, every later stage flips, so the output is the complement of idle.
    assert_first_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((norm == {{(N_PADS-1){1'b1}}, 1'b0})) |-> (chain_out == !IDLE_RESULT));

endmodule

// File: rtl/tmc_oe_force.sv
// Module: tmc_oe_force
// Selects, per stored mode, the pad enables, the result pad data and enable, and the auxiliary enable.
// Assumes: the mode comes from a register. The chain output may change within a cycle.
module tmc_oe_force
    import tmc_pkg::*;
#(
    parameter int N_PADS = 16
) (
    input  tm_mode_e          mode,
    input  logic [N_PADS-1:0] core_oe,
    input  logic              core_res_o,
    input  logic              core_res_oe,
    input  logic              core_aux_oe,
    input  logic              chain_out,
    output logic [N_PADS-1:0] pad_oe,
    output logic              result_o,
    output logic              result_oe,
    output logic              aux_oe
);

    // Enable and data selection for each mode.
    always_comb begin
        unique case (mode)
            TM_CHAIN: begin
                pad_oe    = '0;
                result_o  = chain_out;
                result_oe = 1'b1;
                aux_oe    = 1'b1;
            end
            TM_TRISTATE: begin
                pad_oe    = '0;
                result_o  = core_res_o;
                result_oe = 1'b0;
                aux_oe    = 1'b0;
            end
            default: begin
                pad_oe    = core_oe;
                result_o  = core_res_o;
                result_oe = core_res_oe;
                aux_oe    = core_aux_oe;
            end
        endcase
    end

endmodule

// File: rtl/test_mode_ctrl.sv
// Module: test_mode_ctrl (top)
// Manufacturing test mode controller: decodes the mode, stores it, forces the pad enables and builds the NAND chain.
// Assumes: every input is synchronous to clk. Pad electrical behaviour is outside this block.
module test_mode_ctrl
    import tmc_pkg::*;
#(
    parameter int                N_PADS   = 16,
    parameter logic [N_PADS-1:0] INV_MASK = 16'h0F30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_n,
    input  logic [2:0]        sel,
    input  logic              pwr_good,
    input  logic [N_PADS-1:0] chain_in,
    input  logic [N_PADS-1:0] core_oe,
    input  logic              core_res_o,
    input  logic              core_res_oe,
    input  logic              core_aux_oe,
    output logic [N_PADS-1:0] pad_oe,
    output logic              result_o,
    output logic              result_oe,
    output logic              aux_oe
);

    tm_mode_e mode_dec;
    tm_mode_e mode_q;
    logic     chain_out;

    tmc_mode_decode i_decode (
        .test_n   (test_n),
        .sel      (sel),
        .mode_dec (mode_dec)
    );

    tmc_mode_latch i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .mode_dec (mode_dec),
        .mode_q   (mode_q)
    );

    tmc_nand_chain #(
        .N_PADS   (N_PADS),
        .INV_MASK (INV_MASK)
    ) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .chain_in  (chain_in),
        .chain_out (chain_out)
    );

    tmc_oe_force #(
        .N_PADS (N_PADS)
    ) i_force (
        .mode        (mode_q),
        .core_oe     (core_oe),
        .core_res_o  (core_res_o),
        .core_res_oe (core_res_oe),
        .core_aux_oe (core_aux_oe),
        .chain_out   (chain_out),
        .pad_oe      (pad_oe),
        .result_o    (result_o),
        .result_oe   (result_oe),
        .aux_oe      (aux_oe)
    );

    // R6: high-impedance mode leaves every enable low.
    assert_tristate_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_TRISTATE) |-> (pad_oe == '0 && !result_oe && !aux_oe));

    // R8: chain mode releases the row and keeps the two named pads driving.
    assert_chain_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_CHAIN) |-> (pad_oe == '0 && result_oe && aux_oe));

    // R1: normal mode passes the core enables through unchanged.
    assert_normal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_NORMAL) |-> (pad_oe == core_oe && result_oe == core_res_oe
                                   && aux_oe == core_aux_oe));

    // R12: outside chain mode, the result pad carries the core data.
    assert_result_core_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != TM_CHAIN) |-> (result_o == core_res_o));

endmodule

// File: tb/test_test_mode_ctrl.sv
module test_test_mode_ctrl;

    localparam int                N     = 16;
    localparam logic [N-1:0]      MASK  = 16'h0F30;
    localparam logic [N-1:0]      IDLE  = ~MASK;
    localparam logic [N-1:0]      CORE  = 16'hA5C3;

    typedef struct {
        string        tag;
        logic [N-1:0] pad_oe;
        logic         res_oe;
        logic         aux_oe;
        logic         res;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         test_n;
    logic [2:0]   sel;
    logic         pwr_good;
    logic [N-1:0] chain_in;
    logic [N-1:0] core_oe;
    logic         core_res_o;
    logic         core_res_oe;
    logic         core_aux_oe;
    logic [N-1:0] pad_oe;
    logic         result_o;
    logic         result_oe;
    logic         aux_oe;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #4 clk = ~clk;

    test_mode_ctrl #(.N_PADS(N), .INV_MASK(MASK)) i_test_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .test_n(test_n), .sel(sel), .pwr_good(pwr_good),
        .chain_in(chain_in), .core_oe(core_oe), .core_res_o(core_res_o),
        .core_res_oe(core_res_oe), .core_aux_oe(core_aux_oe),
        .pad_oe(pad_oe), .result_o(result_o), .result_oe(result_oe), .aux_oe(aux_oe)
    );

    // Driver side: records what the ports should show now.
    task automatic push(input string tag, input logic [N-1:0] p, input logic ro,
                        input logic ao, input logic r);
        exp_t e;
        e.tag = tag; e.pad_oe = p; e.res_oe = ro; e.aux_oe = ao; e.res = r;
        q.push_back(e);
        #1;
    endtask

    task automatic push_normal(input string tag);
        push(tag, core_oe, core_res_oe, core_aux_oe, core_res_o);
    endtask

    task automatic push_chain(input string tag, input logic r);
        push(tag, '0, 1'b1, 1'b1, r);
    endtask

    // A power-good pulse, with test_n and sel held at the capture edge.
    task automatic capture(input logic tn, input logic [2:0] s);
        @(negedge clk);
        test_n = tn; sel = s; pwr_good = 1'b1;
        @(posedge clk);
        #2;
    endtask

    task automatic pg_low();
        @(negedge clk);
        pwr_good = 1'b0;
        @(posedge clk);
        #2;
    endtask

    // Monitor: takes each expected item and compares it with the ports.
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (pad_oe !== e.pad_oe || result_oe !== e.res_oe ||
                    aux_oe !== e.aux_oe || result_o !== e.res) begin
                    n_fail++;
                    $display("FAIL %s: got oe=%h res_oe=%b aux_oe=%b res=%b, expected oe=%h res_oe=%b aux_oe=%b res=%b",
                             e.tag, pad_oe, result_oe, aux_oe, result_o,
                             e.pad_oe, e.res_oe, e.aux_oe, e.res);
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp_r;
        rst_n = 1'b0; test_n = 1'b1; sel = 3'b000; pwr_good = 1'b0;
        chain_in = IDLE; core_oe = CORE; core_res_o = 1'b1;
        core_res_oe = 1'b1; core_aux_oe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        push_normal("R1 reset normal");
        core_oe = 16'h1234; core_res_oe = 1'b0; core_aux_oe = 1'b1; core_res_o = 1'b0;
        push_normal("R1 core passthrough");

        // R2: test_n high wins over a chain code.
        capture(1'b1, 3'b001);
        push_normal("R2 test_n high");
        pg_low();

        // R3: select changes without a power-good edge are ignored.
        @(negedge clk); test_n = 1'b0; sel = 3'b101;
        @(posedge clk); #2;
        push_normal("R3 no edge no change");

        // R6: high-impedance mode.
        capture(1'b0, 3'b101);
        push("R6 tristate", '0, 1'b0, 1'b0, core_res_o);
        @(negedge clk); sel = 3'b000;
        @(posedge clk); #2;
        push("R3 held while pg high", '0, 1'b0, 1'b0, core_res_o);
        pg_low();

        // R7: the two normal codes.
        capture(1'b0, 3'b100);
        push_normal("R7 sel 100 normal");
        pg_low();
        capture(1'b0, 3'b101);
        pg_low();
        capture(1'b0, 3'b111);
        push_normal("R7 sel 111 normal");
        pg_low();

        // R5: the second chain code.
        capture(1'b0, 3'b110);
        push_chain("R5 sel 110 chain R8", 1'b1);
        pg_low();
        capture(1'b0, 3'b100);
        pg_low();

        // R4: the first chain code, with sel[1:0] set to 11.
        capture(1'b0, 3'b011);
        push_chain("R4 sel 011 chain R8", 1'b1);
        pg_low();

        // R9 idle level, then the R10/R11 stepwise walk.
        exp_r = ((N % 2) == 0);
        push_chain("R9 idle result", exp_r);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            chain_in[k] = ~chain_in[k];
            #1;
            exp_r = ~exp_r;
            if (MASK[k]) push_chain($sformatf("R11 inverting pad %0d toggle", k), exp_r);
            else         push_chain($sformatf("R10 pad %0d toggle", k), exp_r);
        end

        // R12: normal mode again, with the result pad following the core.
        capture(1'b0, 3'b100);
        core_res_o = 1'b1;
        push_normal("R12 core result high");
        core_res_o = 1'b0;
        push_normal("R12 core result low");
        pg_low();

        // R4: sel 000 gives chain mode again.
        chain_in = IDLE;
        capture(1'b0, 3'b000);
        push_chain("R4 sel 000 chain", ((N % 2) == 0));
        pg_low();

        #20;
        wait (q.size() == 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule